// File: doc/BRIEF.md
# Interrupt-on-Change GPIO Port

An eight-pin general-purpose I/O port controlled through a small register file on a simple synchronous read/write bus. Software sets each pin's direction, output level, pull-up enable and input inversion. It reads the live (synchronized) pin levels back through the port register. The pad itself is outside the block: the block drives an output value and an output enable per pin, and a pull-up enable per pin.

Each enabled pin can raise an interrupt in one of two ways. In change mode it interrupts when its level differs from the level one cycle earlier. In default mode it interrupts for as long as its level differs from a programmed reference bit. When an interrupt becomes pending, a flag register records one responsible pin and a capture register freezes the port value. Both stay frozen until the interrupt is cleared. The clear happens on a bus read of either the port register or the capture register, chosen by a configuration bit. The interrupt line can be push-pull of either polarity, or open-drain.

Top module: `gpio_ioc_port`

## Requirements
- R1: After reset the direction register reads 0xFF, every other register reads 0x00, no pin output is enabled, no pull-up is enabled, and the interrupt line is inactive.
- R2: Direction bit 1 means input: `pin_oe` is the inverse of the direction register. `pin_out` follows the output latch (address 0x0A). A write to the port address (0x09) also loads the latch, and reading 0x0A returns the latch.
- R3: Reading the port address returns the synchronized pin levels XOR the inversion register (address 0x01).
- R4: `pull_en` equals the pull-up register (address 0x06), which reads back as written.
- R5: A pin whose enable bit (address 0x02) is 1 and whose mode bit (address 0x04) is 0 makes the interrupt pending when its level changes. A change on a pin with enable bit 0 never does.
- R6: With mode bit 1, an enabled pin makes the interrupt pending while its level differs from its bit in the reference register (address 0x03). A clear taken while the difference remains is followed by a new pending interrupt.
- R7: The flag register (address 0x07) is zero when nothing is pending. Otherwise it holds exactly one set bit: the lowest-numbered pin among those that triggered in the same cycle.
- R8: The capture register (address 0x08) takes the port value (pin levels XOR inversion) in the cycle the interrupt becomes pending. While the interrupt stays pending, the flag and capture registers do not change. Capture keeps its value after a clear.
- R9: With configuration (address 0x05) bit 0 at 0, a bus read of the port address clears the pending interrupt and the flag. A read of the capture address does not.
- R10: With configuration bit 0 at 1, a bus read of the capture address clears the pending interrupt and the flag. A read of the port address does not.
- R11: Configuration bit 2 at 1 selects open-drain: `irq_o` is 0, and `irq_oe` is 1 exactly while pending. With bit 2 at 0, `irq_oe` is 1 and `irq_o` is the pending state, inverted unless configuration bit 1 is set.
- R12: Flag and capture are read-only, so bus writes to 0x07 and 0x08 leave them unchanged. Writes to unused addresses are ignored, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, marks a read that may clear the interrupt |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| pull_en | output | 8 | Pull-up enables |
| irq_o | output | 1 | Interrupt line value |
| irq_oe | output | 1 | Interrupt line drive enable |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that a clearing read is recognised from the current configuration bit 0, so software must not change that bit in the same cycle as the read. The stimulus issues one bus operation per cycle with the strobes driven at the falling edge. It changes the pins only while the bus is idle and then waits long enough for the two-stage synchronizer and the event register. As a result, no pin event ever coincides with a clearing read.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 4;

    typedef logic [PORT_W-1:0] port_t;

    localparam logic [ADDR_W-1:0] A_DIR  = 4'h0;
    localparam logic [ADDR_W-1:0] A_POL  = 4'h1;
    localparam logic [ADDR_W-1:0] A_IEN  = 4'h2;
    localparam logic [ADDR_W-1:0] A_REF  = 4'h3;
    localparam logic [ADDR_W-1:0] A_MODE = 4'h4;
    localparam logic [ADDR_W-1:0] A_CFG  = 4'h5;
    localparam logic [ADDR_W-1:0] A_PUP  = 4'h6;
    localparam logic [ADDR_W-1:0] A_FLAG = 4'h7;
    localparam logic [ADDR_W-1:0] A_CAP  = 4'h8;
    localparam logic [ADDR_W-1:0] A_PORT = 4'h9;
    localparam logic [ADDR_W-1:0] A_LAT  = 4'hA;

    localparam int CFG_CLRSEL = 0;  // 1: capture read clears
    localparam int CFG_ACTHI  = 1;  // push-pull active-high
    localparam int CFG_ODRAIN = 2;  // open-drain line

    typedef struct packed {
        port_t dir;
        port_t pol;
        port_t ien;
        port_t refv;
        port_t mode;
        port_t cfg;
        port_t pup;
        port_t lat;
        port_t flag;
        port_t cap;
        port_t prev;
        logic  pend;
    } ioc_state_t;
endpackage

// File: rtl/gpio_ioc_sync.sv
module gpio_ioc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_ioc_detect.sv
module gpio_ioc_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] refv,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] ien,
    output logic [W-1:0] hit,
    output logic [W-1:0] first
);
    // per-pin event: level-vs-reference or level-vs-previous
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign hit[i] = ien[i] & (mode[i] ? (lvl[i] ^ refv[i]) : (lvl[i] ^ prev[i]));
    end

    // isolate the lowest set bit
    assign first = hit & (~hit + 1'b1);
endmodule

// File: rtl/gpio_ioc_irqdrv.sv
module gpio_ioc_irqdrv (
    input  logic active,
    input  logic act_high,
    input  logic open_drain,
    output logic line_o,
    output logic line_oe
);
    always_comb begin
        if (open_drain) begin
            line_o  = 1'b0;
            line_oe = active;
        end else begin
            line_o  = act_high ? active : ~active;
            line_oe = 1'b1;
        end
    end
endmodule

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port
    import gpio_ioc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pull_en,
    output logic              irq_o,
    output logic              irq_oe
);
    ioc_state_t st_d, st_q;
    port_t      pin_s;
    port_t      hit, first;
    logic       clr;

    gpio_ioc_sync #(.W(PORT_W), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (pin_s)
    );

    gpio_ioc_detect #(.W(PORT_W)) u_detect (
        .lvl  (pin_s),
        .prev (st_q.prev),
        .refv (st_q.refv),
        .mode (st_q.mode),
        .ien  (st_q.ien),
        .hit  (hit),
        .first(first)
    );

    gpio_ioc_irqdrv u_irqdrv (
        .active    (st_q.pend),
        .act_high  (st_q.cfg[CFG_ACTHI]),
        .open_drain(st_q.cfg[CFG_ODRAIN]),
        .line_o    (irq_o),
        .line_oe   (irq_oe)
    );

    always_comb begin
        clr  = bus_rd && (bus_addr == (st_q.cfg[CFG_CLRSEL] ? A_CAP : A_PORT));
        st_d = st_q;
        st_d.prev = pin_s;
        if (bus_wr) begin
            case (bus_addr)
                A_DIR:          st_d.dir  = bus_wdata;
                A_POL:          st_d.pol  = bus_wdata;
                A_IEN:          st_d.ien  = bus_wdata;
                A_REF:          st_d.refv = bus_wdata;
                A_MODE:         st_d.mode = bus_wdata;
                A_CFG:          st_d.cfg  = bus_wdata;
                A_PUP:          st_d.pup  = bus_wdata;
                A_PORT, A_LAT:  st_d.lat  = bus_wdata;
                default:        ;
            endcase
        end
        if (clr) begin
            st_d.pend = 1'b0;
            st_d.flag = '0;
        end
        if (!st_d.pend && (|hit)) begin
            st_d.pend = 1'b1;
            st_d.flag = first;
            st_d.cap  = pin_s ^ st_q.pol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.dir <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_addr)
            A_DIR:   bus_rdata = st_q.dir;
            A_POL:   bus_rdata = st_q.pol;
            A_IEN:   bus_rdata = st_q.ien;
            A_REF:   bus_rdata = st_q.refv;
            A_MODE:  bus_rdata = st_q.mode;
            A_CFG:   bus_rdata = st_q.cfg;
            A_PUP:   bus_rdata = st_q.pup;
            A_FLAG:  bus_rdata = st_q.flag;
            A_CAP:   bus_rdata = st_q.cap;
            A_PORT:  bus_rdata = pin_s ^ st_q.pol;
            A_LAT:   bus_rdata = st_q.lat;
            default: bus_rdata = '0;
        endcase
    end

    assign pin_out = st_q.lat;
    assign pin_oe  = ~st_q.dir;
    assign pull_en = st_q.pup;
endmodule

// File: rtl/gpio_ioc_chk.sv
module gpio_ioc_chk
    import gpio_ioc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input port_t             cfg,
    input port_t             ien,
    input port_t             flag,
    input port_t             cap,
    input logic              pend,
    input logic              irq_o,
    input logic              irq_oe
);
    logic clr_seen;
    assign clr_seen = bus_rd && (bus_addr == (cfg[CFG_CLRSEL] ? A_CAP : A_PORT));

    AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(flag)); // R7
    AST_FLAG_PEND:   assert property (@(posedge clk) disable iff (!rst_n) pend == (flag != '0)); // R7
    AST_FROZEN:      assert property (@(posedge clk) disable iff (!rst_n) (pend && !clr_seen) |=> ($stable(flag) && $stable(cap))); // R8
    AST_EN_ONLY:     assert property (@(posedge clk) disable iff (!rst_n) $rose(pend) |-> ($past(ien) != '0)); // R5
    AST_OD_LOW:      assert property (@(posedge clk) disable iff (!rst_n) cfg[CFG_ODRAIN] |-> (!irq_o && (irq_oe == pend))); // R11
    AST_PP_DRIVE:    assert property (@(posedge clk) disable iff (!rst_n) !cfg[CFG_ODRAIN] |-> irq_oe); // R11
endmodule

bind gpio_ioc_port gpio_ioc_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_rd  (bus_rd),
    .bus_addr(bus_addr),
    .cfg     (st_q.cfg),
    .ien     (st_q.ien),
    .flag    (st_q.flag),
    .cap     (st_q.cap),
    .pend    (st_q.pend),
    .irq_o   (irq_o),
    .irq_oe  (irq_oe)
);

// File: tb/gpio_ioc_port_tb.sv
module gpio_ioc_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] pin_in = '0, pin_out, pin_oe, pull_en;
    logic       irq_o, irq_oe;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_ioc_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
        .irq_o(irq_o), .irq_oe(irq_oe)
    );

    localparam logic [2:0] WR = 3'd0, RD = 3'd1, PIN = 3'd2, IRQ = 3'd3,
                           OE = 3'd4, OUT = 3'd5, PU = 3'd6;
    localparam int NV = 77;
    // {requirement, op, address, data/expected}; IRQ data = {irq_oe, irq_o}
    localparam logic [18:0] VEC [NV] = '{
        {4'd2, WR, 4'h0, 8'hF0},  {4'd2, OE, 4'h0, 8'h0F},   // R2
        {4'd2, WR, 4'hA, 8'hA5},  {4'd2, OUT, 4'h0, 8'hA5},  // R2
        {4'd2, RD, 4'hA, 8'hA5},  {4'd2, WR, 4'h9, 8'h3C},   // R2
        {4'd2, OUT, 4'h0, 8'h3C}, {4'd2, RD, 4'hA, 8'h3C},   // R2
        {4'd4, WR, 4'h6, 8'h81},  {4'd4, PU, 4'h0, 8'h81},   // R4
        {4'd4, RD, 4'h6, 8'h81},                             // R4
        {4'd3, PIN, 4'h0, 8'h5A}, {4'd3, RD, 4'h9, 8'h5A},   // R3
        {4'd3, WR, 4'h1, 8'h0F},  {4'd3, RD, 4'h9, 8'h55},   // R3
        {4'd3, WR, 4'h1, 8'h00},                             // R3
        {4'd5, WR, 4'h2, 8'h01},  {4'd5, PIN, 4'h0, 8'h58},  // R5 disabled pin moves
        {4'd5, IRQ, 4'h0, 8'h03}, {4'd5, RD, 4'h7, 8'h00},   // R5
        {4'd5, PIN, 4'h0, 8'h59}, {4'd5, IRQ, 4'h0, 8'h02},  // R5 enabled pin moves
        {4'd7, RD, 4'h7, 8'h01},  {4'd8, RD, 4'h8, 8'h59},   // R7 R8
        {4'd8, PIN, 4'h0, 8'h58}, {4'd8, RD, 4'h8, 8'h59},   // R8 frozen
        {4'd8, RD, 4'h7, 8'h01},                             // R8
        {4'd9, RD, 4'h9, 8'h58},  {4'd9, IRQ, 4'h0, 8'h03},  // R9
        {4'd9, RD, 4'h7, 8'h00},  {4'd8, RD, 4'h8, 8'h59},   // R9 R8 kept
        {4'd7, WR, 4'h2, 8'hFF},  {4'd7, PIN, 4'h0, 8'h5E},  // R7 two pins
        {4'd7, RD, 4'h7, 8'h02},  {4'd8, RD, 4'h8, 8'h5E},   // R7 R8
        {4'd9, RD, 4'h9, 8'h5E},  {4'd9, IRQ, 4'h0, 8'h03},  // R9
        {4'd6, WR, 4'h2, 8'h10},  {4'd6, WR, 4'h3, 8'h10},   // R6
        {4'd6, WR, 4'h4, 8'h10},  {4'd6, IRQ, 4'h0, 8'h03},  // R6 equal ref
        {4'd6, PIN, 4'h0, 8'h4E}, {4'd6, RD, 4'h7, 8'h10},   // R6
        {4'd6, RD, 4'h9, 8'h4E},  {4'd6, IRQ, 4'h0, 8'h02},  // R6 re-raise
        {4'd6, RD, 4'h7, 8'h10},  {4'd6, PIN, 4'h0, 8'h5E},  // R6
        {4'd6, RD, 4'h9, 8'h5E},  {4'd6, IRQ, 4'h0, 8'h03},  // R6
        {4'd10, WR, 4'h5, 8'h01}, {4'd10, WR, 4'h4, 8'h00},  // R10
        {4'd10, WR, 4'h2, 8'h80}, {4'd10, PIN, 4'h0, 8'hDE}, // R10
        {4'd10, RD, 4'h9, 8'hDE}, {4'd10, IRQ, 4'h0, 8'h02}, // R10 port read keeps
        {4'd10, RD, 4'h8, 8'hDE}, {4'd10, IRQ, 4'h0, 8'h03}, // R10 capture read clears
        {4'd11, WR, 4'h5, 8'h02}, {4'd11, IRQ, 4'h0, 8'h02}, // R11
        {4'd11, PIN, 4'h0, 8'h5E}, {4'd11, IRQ, 4'h0, 8'h03},// R11
        {4'd11, WR, 4'h5, 8'h06}, {4'd11, IRQ, 4'h0, 8'h02}, // R11
        {4'd11, RD, 4'h9, 8'h5E}, {4'd11, IRQ, 4'h0, 8'h00}, // R11
        {4'd12, WR, 4'h7, 8'hFF}, {4'd12, RD, 4'h7, 8'h00},  // R12
        {4'd12, WR, 4'h8, 8'h00}, {4'd12, RD, 4'h8, 8'h5E},  // R12
        {4'd8, WR, 4'h5, 8'h00},  {4'd8, WR, 4'h1, 8'hFF},   // R8
        {4'd8, WR, 4'h2, 8'h01},  {4'd8, PIN, 4'h0, 8'h5F},  // R8
        {4'd8, RD, 4'h8, 8'hA0},  {4'd8, RD, 4'h9, 8'hA0},   // R8 inverted capture
        {4'd8, IRQ, 4'h0, 8'h03}, {4'd8, WR, 4'h1, 8'h00}    // R8
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input int req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 check(req, bus_rdata, exp);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        do_rd(1, 4'h0, 8'hFF);
        do_rd(1, 4'h5, 8'h00);
        do_rd(1, 4'hA, 8'h00);
        do_rd(1, 4'h7, 8'h00);
        settle();
        check(1, {6'd0, irq_oe, irq_o}, 8'h03);
        check(1, pin_oe, 8'h00);

        for (int v = 0; v < NV; v++) begin
            logic [3:0] rq; logic [2:0] op; logic [3:0] ad; logic [7:0] dt;
            {rq, op, ad, dt} = VEC[v];
            case (op)
                WR:  do_wr(ad, dt);
                RD:  do_rd(rq, ad, dt);
                PIN: begin
                    @(negedge clk); pin_in = dt;
                    repeat (4) @(posedge clk);
                end
                IRQ: begin settle(); check(rq, {6'd0, irq_oe, irq_o}, dt); end
                OE:  begin settle(); check(rq, pin_oe, dt); end
                OUT: begin settle(); check(rq, pin_out, dt); end
                default: begin settle(); check(rq, pull_en, dt); end
            endcase
        end

        // R12 unused address reads zero and ignores writes
        do_wr(4'hD, 8'h77);
        do_rd(12, 4'hD, 8'h00);

        // R1 reset in mid-run returns everything to its initial state
        do_wr(4'h5, 8'h06);
        do_wr(4'h6, 8'hFF);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        do_rd(1, 4'h0, 8'hFF);
        do_rd(1, 4'h5, 8'h00);
        do_rd(1, 4'h6, 8'h00);
        settle();
        check(1, pull_en, 8'h00);
        check(1, {6'd0, irq_oe, irq_o}, 8'h03);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual running expected finished");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule